// File: doc/BRIEF.md
# EDO Page-Mode DRAM Access Controller

This block sits between a simple synchronous host port and an x4 extended-data-out DRAM with a multiplexed 11-bit address bus. Each host request carries a 22-bit word address, a write flag and a 4-bit data nibble. The controller turns it into a sequence of row strobe, column strobe, write-enable and output-enable levels. The upper 11 address bits go out as the row and the lower 11 bits as the column. Read results come back on a one-cycle data-valid pulse, in request order.

After a row is opened it stays open. Later requests to the same row are served with column-strobe cycles only. Read data is captured after the column strobe has risen again, which the DRAM's extended output hold permits. The row is precharged when a request targets a different row, when the row strobe has been low for a configurable number of cycles, or when an external refresh agent asks for the array. In that last case the controller parks every strobe high and raises a grant until the request is withdrawn. All DRAM timing minimums are parameters given in clock cycles.

Top module: `edo_page_ctrl`

## Requirements
- R1: The row address, equal to request address bits [21:11], is on `dram_addr` when `dram_ras_n` falls. The column address, equal to bits [10:0], is on `dram_addr` when `dram_cas_n` falls.
- R2: A read keeps `dram_we_n` high and `dram_dq_oe` low when `dram_cas_n` falls. It holds `dram_oe_n` low while the column strobe is low and during the precharge that follows. It captures `dram_dq_in` after the column strobe has risen. The result appears on `rd_data` with a single-cycle `rd_valid` pulse, and reads complete in request order.
- R3: An early write drives `dram_we_n` low in the same cycle that `dram_cas_n` falls. It drives the write nibble with `dram_dq_oe` high for the whole time the column strobe is low, and keeps `dram_oe_n` high.
- R4: The row strobe is low for at least T_RCD cycles before the column strobe falls. The column strobe is low for at least T_CAS cycles (T_CAS of at least 2). Between two column pulses in one row, the column strobe is high for at least T_CP cycles.
- R5: A request whose row matches the open row is served without a new falling edge of `dram_ras_n`. With no request pending, the row stays open.
- R6: A request to another row first raises `dram_ras_n` for at least T_RP cycles (T_RP of at least 2), then opens the new row.
- R7: Once the row strobe has been low for RAS_MAX_CYC cycles, the row is closed at the next page boundary.
- R8: A refresh request is served only while no column cycle is in progress. The row is closed first. Then `refresh_grant` is high with all four strobes high and `req_ready` low until `refresh_req` drops.
- R9: During and after reset, every strobe is high, `refresh_grant` and `rd_valid` are low, and `req_ready` is high.
- R10: `dram_cas_n` is never low while `dram_ras_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller accepts the request this cycle |
| req_addr | input | 22 | Word address, row in [21:11], column in [10:0] |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 4 | Write nibble |
| rd_valid | output | 1 | Read result valid (one cycle) |
| rd_data | output | 4 | Read result |
| refresh_req | input | 1 | External refresh agent asks for the array |
| refresh_grant | output | 1 | Array idle, strobes parked high |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_dq_out | output | 4 | Data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 4 | Data from the DRAM |

## Verification
A stale open-row register is a dangerous fault. It does not hang the controller. It shows up as a column cycle with no row strobe edge, so the first read to the new row returns data from the old row. The scoreboard flags that at the next `rd_valid`. A sequencer that loses track of the strobes shows up within a few cycles as a column pulse that is too short, a short precharge, or a column strobe without the row strobe. The DRAM model in the bench checks each of these at the edge where it happens. A broken row-low counter leaves the row open long past the limit, which a port check a fixed number of cycles later detects.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,  // row closed and precharged
    ST_ACT  = 3'd1,  // row strobe low, waiting before column strobe
    ST_CAS  = 3'd2,  // column strobe low
    ST_CP   = 3'd3,  // column precharge, read data still valid
    ST_OPEN = 3'd4,  // row open, waiting for a request
    ST_PRE  = 3'd5,  // row precharge
    ST_REF  = 3'd6   // array handed to the refresh agent
  } edo_state_e;
endpackage

// File: rtl/edo_cyc_timer.sv
module edo_cyc_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)             cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/edo_ras_window.sv
module edo_ras_window #(
  parameter int MAX_CYC = 9000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_low,
  output logic expired
);
  localparam int CW = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_CYC);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = '0;
    if (ras_low) cnt_d = (cnt_q == LIMIT) ? cnt_q : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == LIMIT);
endmodule

// File: rtl/edo_row_track.sv
module edo_row_track #(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_en,
  input  logic [ROW_W-1:0] open_row,
  input  logic             close_en,
  input  logic [ROW_W-1:0] cmp_row,
  output logic             hit
);
  logic             vld_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        vld_q <= 1'b0;
    else if (open_en)  vld_q <= 1'b1;
    else if (close_en) vld_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       row_q <= '0;
    else if (open_en) row_q <= open_row;
  end

  assign hit = vld_q && (row_q == cmp_row);
endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
  import edo_pkg::*;
#(
  parameter int ROW_W       = 11,
  parameter int COL_W       = 11,
  parameter int DQ_W        = 4,
  parameter int T_RCD       = 4,
  parameter int T_CAS       = 2,
  parameter int T_CP        = 1,
  parameter int T_RP        = 4,
  parameter int RAS_MAX_CYC = 9000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ROW_W+COL_W-1:0]   req_addr,
  input  logic                     req_write,
  input  logic [DQ_W-1:0]          req_wdata,
  output logic                     rd_valid,
  output logic [DQ_W-1:0]          rd_data,
  input  logic                     refresh_req,
  output logic                     refresh_grant,
  output logic                     dram_ras_n,
  output logic                     dram_cas_n,
  output logic                     dram_we_n,
  output logic                     dram_oe_n,
  output logic [ROW_W-1:0]         dram_addr,
  output logic [DQ_W-1:0]          dram_dq_out,
  output logic                     dram_dq_oe,
  input  logic [DQ_W-1:0]          dram_dq_in
);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int T_MAX  = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int TMR_W  = $clog2(T_MAX + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  edo_state_e         state_q, state_d;
  logic               pend_q, pend_d;
  logic [ADDR_W-1:0]  rq_addr_q;
  logic               rq_wr_q;
  logic [DQ_W-1:0]    rq_wd_q;
  logic               accept, hit, tmr_done, tmr_load, ras_expired, ras_low;
  logic [TMR_W-1:0]   tmr_val;
  logic               cap_en;
  logic [DQ_W-1:0]    rd_data_q;
  logic               rd_valid_q;

  wire [ROW_W-1:0] req_row = req_addr[ADDR_W-1:COL_W];
  wire [ROW_W-1:0] rq_row  = rq_addr_q[ADDR_W-1:COL_W];
  wire [COL_W-1:0] rq_col  = rq_addr_q[COL_W-1:0];

  assign ras_low   = (state_q == ST_ACT) || (state_q == ST_CAS) ||
                     (state_q == ST_CP)  || (state_q == ST_OPEN);
  assign req_ready = !refresh_req &&
                     ((state_q == ST_IDLE) || ((state_q == ST_OPEN) && !ras_expired));
  assign accept    = req_valid && req_ready;

  // next-state process
  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    unique case (state_q)
      ST_IDLE: if (refresh_req) state_d = ST_REF;
               else if (accept) state_d = ST_ACT;
      ST_ACT:  if (tmr_done) state_d = ST_CAS;
      ST_CAS:  if (tmr_done) state_d = ST_CP;
      ST_CP:   if (tmr_done) state_d = ST_OPEN;
      ST_OPEN: if (refresh_req || ras_expired) state_d = ST_PRE;
               else if (accept) begin
                 if (hit) state_d = ST_CAS;
                 else begin state_d = ST_PRE; pend_d = 1'b1; end
               end
      ST_PRE:  if (tmr_done) begin
                 if (pend_q) begin state_d = ST_ACT; pend_d = 1'b0; end
                 else if (refresh_req) state_d = ST_REF;
                 else state_d = ST_IDLE;
               end
      ST_REF:  if (!refresh_req) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // per-state wait length, loaded on entry
  always_comb begin
    tmr_load = (state_d != state_q);
    unique case (state_d)
      ST_ACT:  tmr_val = TMR_W'(T_RCD - 1);
      ST_CAS:  tmr_val = TMR_W'(T_CAS - 1);
      ST_CP:   tmr_val = TMR_W'(T_CP - 1);
      ST_PRE:  tmr_val = TMR_W'(T_RP - 1);
      default: tmr_val = '0;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rq_addr_q <= '0;
      rq_wr_q   <= 1'b0;
      rq_wd_q   <= '0;
    end else if (accept) begin
      rq_addr_q <= req_addr;
      rq_wr_q   <= req_write;
      rq_wd_q   <= req_wdata;
    end
  end

  assign cap_en = (state_q == ST_CP) && tmr_done && !rq_wr_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rd_valid_q <= 1'b0;
    else            rd_valid_q <= cap_en;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  rd_data_q <= '0;
    else if (cap_en) rd_data_q <= dram_dq_in;
  end

  edo_cyc_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  edo_ras_window #(.MAX_CYC(RAS_MAX_CYC)) u_window (
    .clk(clk), .rst_n(rst_int_n), .ras_low(ras_low), .expired(ras_expired)
  );

  edo_row_track #(.ROW_W(ROW_W)) u_rows (
    .clk(clk), .rst_n(rst_int_n),
    .open_en((state_d == ST_ACT) && (state_q != ST_ACT)),
    .open_row(accept ? req_row : rq_row),
    .close_en((state_d == ST_PRE) && (state_q != ST_PRE)),
    .cmp_row(req_row), .hit(hit)
  );

  assign dram_ras_n    = !ras_low;
  assign dram_cas_n    = (state_q != ST_CAS);
  assign dram_we_n     = !((state_q == ST_CAS) && rq_wr_q);
  assign dram_oe_n     = !(((state_q == ST_CAS) || (state_q == ST_CP)) && !rq_wr_q);
  assign dram_dq_oe    = (state_q == ST_CAS) && rq_wr_q;
  assign dram_dq_out   = rq_wd_q;
  assign dram_addr     = (state_q == ST_CAS) ? ROW_W'(rq_col) : rq_row;
  assign refresh_grant = (state_q == ST_REF);
  assign rd_valid      = rd_valid_q;
  assign rd_data       = rd_data_q;
endmodule

// File: rtl/edo_page_ctrl_chk.sv
module edo_page_ctrl_chk #(
  parameter int RAS_MAX_CYC = 9000,
  parameter int T_CAS       = 2,
  parameter int T_CP        = 1
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic oe_n,
  input logic dq_oe,
  input logic grant,
  input logic rd_valid
);
  localparam int LIM = RAS_MAX_CYC + T_CAS + T_CP + 2;
  int unsigned low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     low_cnt <= 0;
    else if (ras_n) low_cnt <= 0;
    else if (low_cnt < LIM + 1) low_cnt <= low_cnt + 1;
  end

  a_r10_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);
  a_r8_grant_parks_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (ras_n && cas_n && we_n && oe_n));
  a_r3_write_drives_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (dq_oe && !cas_n && oe_n));
  a_r7_ras_low_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    low_cnt <= LIM);
  a_r4_cas_min_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |=> !cas_n);
  a_r4_ras_before_cas: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $past(!ras_n));
  a_r6_precharge_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> ras_n);
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
endmodule

bind edo_page_ctrl edo_page_ctrl_chk #(
  .RAS_MAX_CYC(RAS_MAX_CYC), .T_CAS(T_CAS), .T_CP(T_CP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
  .we_n(dram_we_n), .oe_n(dram_oe_n), .dq_oe(dram_dq_oe),
  .grant(refresh_grant), .rd_valid(rd_valid)
);

// File: tb/edo_page_ctrl_test.sv
`timescale 1ns/1ps
module edo_page_ctrl_test;
  localparam int    T_RCD = 4, T_CAS = 2, T_CP = 1, T_RP = 4, RMAX = 60;
  localparam real   PER   = 8.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, refresh_req = 1'b0;
  logic [21:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic        req_ready, rd_valid, refresh_grant;
  logic [3:0]  rd_data, dram_dq_out;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [10:0] dram_addr;
  logic [3:0]  dram_dq_in = '0;

  always #(PER/2) clk = ~clk;

  edo_page_ctrl #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP),
                  .RAS_MAX_CYC(RMAX)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .refresh_req(refresh_req),
    .refresh_grant(refresh_grant), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_addr(dram_addr),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  int n_chk = 0, n_bad = 0;
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] dflt(input logic [21:0] a);
    return a[3:0] ^ a[14:11] ^ a[21:18] ^ 4'h6;
  endfunction

  // ---------------- DRAM model with strobe timing checks ----------------
  logic [3:0]  mem [int];
  logic [10:0] m_row, m_col;
  int          ras_falls = 0;
  realtime     t_rf = 0, t_rr = 0, t_cf = 0, t_cr = 0;
  bit          seen_rr = 0, cas_in_row = 0;
  logic [3:0]  w_latched;

  always @(negedge dram_ras_n) if (rst_n) begin
    if (seen_rr) check(($realtime - t_rr) / PER >= T_RP, "R6 precharge",
                       int'(($realtime - t_rr) / PER), T_RP);
    m_row = dram_addr; t_rf = $realtime; ras_falls++; cas_in_row = 0;
  end
  always @(posedge dram_ras_n) if (rst_n) begin
    t_rr = $realtime; seen_rr = 1;
  end
  always @(negedge dram_cas_n) if (rst_n) begin
    logic [21:0] a;
    check(dram_ras_n == 1'b0, "R10 cas with ras", dram_ras_n, 0);
    if (!cas_in_row) check(($realtime - t_rf) / PER >= T_RCD, "R4 ras-to-cas",
                           int'(($realtime - t_rf) / PER), T_RCD);
    else check(($realtime - t_cr) / PER >= T_CP, "R4 cas precharge",
               int'(($realtime - t_cr) / PER), T_CP);
    cas_in_row = 1; t_cf = $realtime;
    m_col = dram_addr; a = {m_row, m_col};
    if (!dram_we_n) begin
      check(dram_dq_oe && dram_oe_n, "R3 write bus", {dram_dq_oe, dram_oe_n}, 3);
      mem[int'(a)] = dram_dq_out; w_latched = dram_dq_out;
    end else begin
      check(!dram_dq_oe && !dram_oe_n, "R2 read bus", {dram_dq_oe, dram_oe_n}, 0);
      dram_dq_in = mem.exists(int'(a)) ? mem[int'(a)] : dflt(a);
    end
  end
  always @(posedge dram_cas_n) if (rst_n) begin
    check(($realtime - t_cf) / PER >= T_CAS, "R4 cas width",
          int'(($realtime - t_cf) / PER), T_CAS);
    if (!dram_we_n || dram_dq_oe)
      check(dram_dq_out == w_latched, "R3 write hold", dram_dq_out, w_latched);
    t_cr = $realtime;
  end

  // ---------------- scoreboard ----------------
  logic [3:0] ref_mem [int];
  logic [3:0] exp_q [$];

  task automatic issue(input logic [21:0] a, input logic w, input logic [3:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    if (w) ref_mem[int'(a)] = d;
    else exp_q.push_back(ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : dflt(a));
    #1 req_valid = 1'b0;
  endtask

  always @(negedge clk) if (rst_n && rd_valid) begin
    if (exp_q.size() == 0) check(0, "R2 unexpected read", rd_data, 0);
    else begin
      logic [3:0] e;
      e = exp_q.pop_front();
      check(rd_data == e, "R2 read data", rd_data, e);
    end
  end

  task automatic drain();
    repeat (25) @(negedge clk);
  endtask

  bit finished = 0;
  initial begin
    #(PER * 150000);
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int rf0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n} == 4'hF, "R9 strobes",
          {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hF);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!refresh_grant && !rd_valid && req_ready, "R9 outputs",
          {refresh_grant, rd_valid, req_ready}, 1);

    // R5/R1: page hits in one row
    rf0 = ras_falls;
    issue({11'h155, 11'd3}, 1, 4'h9);
    issue({11'h155, 11'd4}, 1, 4'hA);
    issue({11'h155, 11'd5}, 1, 4'hB);
    issue({11'h155, 11'd3}, 0, 0);
    issue({11'h155, 11'd4}, 0, 0);
    issue({11'h155, 11'd5}, 0, 0);
    issue({11'h155, 11'h7FF}, 0, 0);
    drain();
    check(ras_falls - rf0 == 1, "R5 one row open", ras_falls - rf0, 1);
    check(m_row == 11'h155, "R1 row bits", m_row, 11'h155);
    check(m_col == 11'h7FF, "R1 column bits", m_col, 11'h7FF);
    check(dram_ras_n == 1'b0, "R5 row kept open", dram_ras_n, 0);

    // R8: refresh while row open
    @(negedge clk); refresh_req = 1'b1;
    for (int i = 0; i < 40 && !refresh_grant; i++) @(negedge clk);
    check(refresh_grant, "R8 grant", refresh_grant, 1);
    rf0 = ras_falls;
    repeat (6) @(negedge clk);
    check({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n} == 4'hF, "R8 strobes parked",
          {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hF);
    check(!req_ready && ras_falls == rf0, "R8 no access", req_ready, 0);
    refresh_req = 1'b0;
    @(negedge clk);
    check(!refresh_grant, "R8 release", refresh_grant, 0);

    // R6: row misses
    rf0 = ras_falls;
    issue({11'h2AA, 11'd1}, 1, 4'h3);
    issue({11'h155, 11'd3}, 0, 0);
    issue({11'h2AA, 11'd1}, 0, 0);
    drain();
    check(ras_falls - rf0 == 3, "R6 new row per miss", ras_falls - rf0, 3);

    // R7: row-low limit
    issue({11'h0F0, 11'd9}, 0, 0);
    repeat (10) @(negedge clk);
    check(dram_ras_n == 1'b0, "R7 open before limit", dram_ras_n, 0);
    repeat (70) @(negedge clk);
    check(dram_ras_n == 1'b1, "R7 closed after limit", dram_ras_n, 1);

    // mixed traffic over three rows
    for (int i = 0; i < 48; i++) begin
      logic [10:0] r;
      r = (i % 3 == 0) ? 11'h155 : ((i % 3 == 1) ? 11'h2AA : 11'h001);
      issue({r, 11'(i * 7 % 16)}, (i % 4) < 2, 4'(i * 5));
    end
    drain();
    check(exp_q.size() == 0, "R2 all reads returned", exp_q.size(), 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule